// File: doc/BRIEF.md
# Port-Based VLAN Egress Filter

This block sits after the address-lookup stage of a 17-port Ethernet switch. The lookup stage gives it two things for each received frame: the number of the port the frame came in on, and a vector of the ports it wants to send the frame to. The block trims that vector with a permission mask that belongs to the ingress port. It then returns the final egress vector.

Each port owns one 17-bit permission mask. Software reads and writes these masks through a paged register window. Two ports that have each other's bit cleared form separate forwarding domains. Traffic between them is dropped even when the lookup asks for it, and this is how physical loops between linked switches are broken.

Requests and results use a valid/ready handshake, and a two-state controller manages it:
- **ST_IDLE**: no result is held.
- **ST_HOLD**: one registered result is on offer.

The controller moves between these states as follows:
- **ACCEPT** (ST_IDLE to ST_HOLD): a request is taken.
- **WAIT** (ST_HOLD to ST_HOLD): the result is held while the consumer stalls.
- **RELOAD** (ST_HOLD to ST_HOLD): the result is drained and a new request is taken in the same cycle.
- **DRAIN** (ST_HOLD to ST_IDLE): the result is drained and no request is taken.

Top module: `vlan_egress_filter`

## Requirements
- R1: After reset every mask reads back as 0x0001FFFF, so every port may reach every port.
- R2: The result for an accepted request is the request's destination vector ANDed with the mask of its ingress port.
- R3: Bits 31:17 of every readback are zero. A write keeps only bits 16:0 of the data (writing 0xABCD0005 reads back 0x00010005).
- R4: A write to page 0x31 at byte offset 4×p, for p in 0..16, replaces the mask of port p. Writes elsewhere have no effect: any other page, an offset that is not a multiple of 4, or an offset above 0x40. Reads of those addresses return zero.
- R5: The result never includes the ingress port's own bit.
- R6: A request uses the mask value present in the cycle it is accepted. A write made in that same cycle, or later, does not change that request's result.
- R7: req_ready is high when no result is held or when res_ready is high. While res_valid is high and res_ready is low, res_vec stays stable and req_ready is low.
- R8: An ingress port number of 17 or more yields an empty result vector.
- R9: If ports 5, 6 and 10 hold mask 0x00000300, none of them reaches another; ports 8 and 9 keep full reach.
- R10: res_valid rises in the cycle after an accept. With res_ready held high, one request is accepted every cycle and the results appear in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_page | input | 8 | Register page select |
| cfg_offset | input | 8 | Byte offset within the page |
| cfg_wr_en | input | 1 | Write strobe for the addressed register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Readback of the addressed register (combinational) |
| req_valid | input | 1 | Filter request present |
| req_ready | output | 1 | Filter can take a request |
| req_port | input | 5 | Ingress port number |
| req_dest | input | 17 | Destination vector from address lookup |
| res_valid | output | 1 | Filtered result present |
| res_ready | input | 1 | Consumer takes the result |
| res_vec | output | 17 | Final egress port vector |

## Verification
The hardest case to reach is a mask write that collides with a frame in flight. The bench raises a request and a write to the same port's mask in one cycle, then stalls the consumer and writes the mask again while the result is held. The held vector must keep the mask value that was present when the request was accepted, even though readback already shows the newer value. The bench then checks back-to-back requests with the consumer never stalling, to confirm the RELOAD path keeps results in order.

// File: rtl/vef_pkg.sv
package vef_pkg;
    localparam int VEF_PORTS  = 17;
    localparam int VEF_REG_W  = 32;
    localparam int VEF_ADDR_W = 8;
    localparam int VEF_PAGE_W = 8;
    localparam int VEF_PORT_W = 5;
    localparam logic [VEF_PAGE_W-1:0] VEF_MASK_PAGE = 8'h31;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } flt_state_e;
endpackage

// File: rtl/vef_addr_decode.sv
module vef_addr_decode #(
    parameter int NUM_PORTS = 17,
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 8,
    parameter int IDX_W     = 5,
    parameter logic [PAGE_W-1:0] MASK_PAGE = 8'h31
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] offset,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] WORD_LIMIT = WORD_W'(NUM_PORTS);

    logic [WORD_W-1:0] word;

    // Registers are 32 bits wide, so a valid offset is a multiple of 4.
    assign word = offset[ADDR_W-1:2];
    assign hit  = (page == MASK_PAGE) && (offset[1:0] == 2'b00) && (word < WORD_LIMIT);
    assign idx  = word[IDX_W-1:0];
endmodule

// File: rtl/vef_mask_bank.sv
module vef_mask_bank #(
    parameter int NUM_PORTS = 17,
    parameter int REG_W     = 32,
    parameter int IDX_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 hit,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_PORTS-1:0] wdata,
    output logic [NUM_PORTS-1:0] masks [NUM_PORTS],
    output logic [REG_W-1:0]     rdata
);
    logic [NUM_PORTS-1:0] rd_sel;

    // One mask register per port; reset value lets every port reach every port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                masks[p] <= '1;
            end else if (wr_en && hit && (idx == IDX_W'(p))) begin
                masks[p] <= wdata;
            end
        end
    end

    always_comb begin
        rd_sel = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit && (idx == IDX_W'(p))) begin
                rd_sel = masks[p];
            end
        end
    end

    assign rdata = {{(REG_W-NUM_PORTS){1'b0}}, rd_sel};
endmodule

// File: rtl/vef_filter_fsm.sv
module vef_filter_fsm #(
    parameter int NUM_PORTS = 17,
    parameter int PORT_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [PORT_W-1:0]    req_port,
    input  logic [NUM_PORTS-1:0] req_dest,
    input  logic [NUM_PORTS-1:0] masks [NUM_PORTS],
    output logic                 res_valid,
    input  logic                 res_ready,
    output logic [NUM_PORTS-1:0] res_vec
);
    import vef_pkg::*;

    flt_state_e           state_q, state_d;
    logic                 accept;
    logic [NUM_PORTS-1:0] sel_mask, own_bit, vec_q;

    // Pick the ingress port's mask and its own bit; an out-of-range port matches nothing.
    always_comb begin
        sel_mask = '0;
        own_bit  = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_port == PORT_W'(p)) begin
                sel_mask   = masks[p];
                own_bit[p] = 1'b1;
            end
        end
    end

    // Output decode per state.
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                res_valid = 1'b0;
            end
            ST_HOLD: begin
                req_ready = res_ready;
                res_valid = 1'b1;
            end
        endcase
    end

    assign accept = req_valid && req_ready;

    // Next state: ACCEPT, WAIT, RELOAD, DRAIN.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = (res_ready && !accept) ? ST_IDLE : ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // The result is captured at accept, so later mask writes cannot reach it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (accept) begin
            vec_q <= req_dest & sel_mask & ~own_bit;
        end
    end

    assign res_vec = vec_q;
endmodule

// File: rtl/vlan_egress_filter.sv
module vlan_egress_filter #(
    parameter int NUM_PORTS = vef_pkg::VEF_PORTS,
    parameter int REG_W     = vef_pkg::VEF_REG_W,
    parameter int ADDR_W    = vef_pkg::VEF_ADDR_W,
    parameter int PAGE_W    = vef_pkg::VEF_PAGE_W,
    parameter int PORT_W    = vef_pkg::VEF_PORT_W,
    parameter logic [PAGE_W-1:0] MASK_PAGE = vef_pkg::VEF_MASK_PAGE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PAGE_W-1:0]    cfg_page,
    input  logic [ADDR_W-1:0]    cfg_offset,
    input  logic                 cfg_wr_en,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [PORT_W-1:0]    req_port,
    input  logic [NUM_PORTS-1:0] req_dest,
    output logic                 res_valid,
    input  logic                 res_ready,
    output logic [NUM_PORTS-1:0] res_vec
);
    localparam int IDX_W = $clog2(NUM_PORTS);

    logic                 hit;
    logic [IDX_W-1:0]     idx;
    logic [NUM_PORTS-1:0] masks [NUM_PORTS];
    logic                 unused_wdata_hi;

    // Write data above the mask width is dropped.
    assign unused_wdata_hi = ^cfg_wdata[REG_W-1:NUM_PORTS];

    vef_addr_decode #(
        .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
        .IDX_W(IDX_W), .MASK_PAGE(MASK_PAGE)
    ) u_dec (
        .page(cfg_page), .offset(cfg_offset), .hit(hit), .idx(idx)
    );

    vef_mask_bank #(
        .NUM_PORTS(NUM_PORTS), .REG_W(REG_W), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .hit(hit), .idx(idx),
        .wdata(cfg_wdata[NUM_PORTS-1:0]), .masks(masks), .rdata(cfg_rdata)
    );

    vef_filter_fsm #(
        .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_port(req_port), .req_dest(req_dest), .masks(masks),
        .res_valid(res_valid), .res_ready(res_ready), .res_vec(res_vec)
    );
endmodule

// File: rtl/vef_checker.sv
module vef_checker #(
    parameter int NUM_PORTS = 17,
    parameter int REG_W     = 32,
    parameter int PORT_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [REG_W-1:0]     cfg_rdata,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [PORT_W-1:0]    req_port,
    input logic [NUM_PORTS-1:0] req_dest,
    input logic                 res_valid,
    input logic                 res_ready,
    input logic [NUM_PORTS-1:0] res_vec
);
    logic [PORT_W-1:0]    cap_port;
    logic [NUM_PORTS-1:0] cap_dest, cap_own;
    logic                 cap_oob;

    // Remember the last accepted request so the held result can be judged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_port <= '0;
            cap_dest <= '0;
        end else if (req_valid && req_ready) begin
            cap_port <= req_port;
            cap_dest <= req_dest;
        end
    end

    always_comb begin
        cap_own = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (cap_port == PORT_W'(p)) cap_own[p] = 1'b1;
        end
    end

    assign cap_oob = (cap_own == '0);

    assert_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_vec & ~cap_dest) == '0));

    assert_no_reflect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_vec & cap_own) == '0));

    assert_oob_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cap_oob) |-> (res_vec == '0));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[REG_W-1:NUM_PORTS] == '0);

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_vec)));

    assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |-> !req_ready);

    assert_accept_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid);
endmodule

bind vlan_egress_filter vef_checker #(
    .NUM_PORTS(NUM_PORTS), .REG_W(REG_W), .PORT_W(PORT_W)
) u_vef_checker (
    .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
    .req_dest(req_dest), .res_valid(res_valid), .res_ready(res_ready),
    .res_vec(res_vec)
);

// File: tb/vlan_egress_filter_bench.sv
module vlan_egress_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_page = '0;
    logic [7:0]  cfg_offset = '0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_port = '0;
    logic [16:0] req_dest = '0;
    logic        res_valid;
    logic        res_ready = 1'b1;
    logic [16:0] res_vec;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vlan_egress_filter u_vlan_egress_filter (
        .clk(clk), .rst_n(rst_n), .cfg_page(cfg_page), .cfg_offset(cfg_offset),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
        .req_dest(req_dest), .res_valid(res_valid), .res_ready(res_ready),
        .res_vec(res_vec)
    );

    typedef struct packed {
        logic [4:0]  port;
        logic [16:0] dest;
        logic [16:0] expect_vec;
    } vec_t;

    // Domain setup: ports 5, 6, 10 masked to 0x300; others at default.
    localparam vec_t TBL [9] = '{
        '{5'd5,  17'h1FFFF, 17'h00300},
        '{5'd10, 17'h00420, 17'h00000},
        '{5'd8,  17'h1FFFF, 17'h1FEFF},
        '{5'd9,  17'h00600, 17'h00400},
        '{5'd5,  17'h00100, 17'h00100},
        '{5'd0,  17'h00001, 17'h00000},
        '{5'd16, 17'h1FFFF, 17'h0FFFF},
        '{5'd17, 17'h1FFFF, 17'h00000},
        '{5'd6,  17'h00020, 17'h00000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] pg, input logic [7:0] ofs, input logic [31:0] d);
        @(negedge clk);
        cfg_page = pg; cfg_offset = ofs; cfg_wdata = d; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] pg, input logic [7:0] ofs, output logic [31:0] d);
        @(negedge clk);
        cfg_page = pg; cfg_offset = ofs; cfg_wr_en = 1'b0;
        #1 d = cfg_rdata;
    endtask

    task automatic send(input logic [4:0] p, input logic [16:0] d, input logic [16:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_port = p; req_dest = d;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " res_valid"}, {31'd0, res_valid}, 32'd1);
        check({tag, " res_vec"}, {15'd0, res_vec}, {15'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 res_valid after reset", {31'd0, res_valid}, 32'd0);
        check("R7 req_ready after reset", {31'd0, req_ready}, 32'd1);
        for (int p = 0; p < 17; p++) begin
            cfg_read(8'h31, 8'(4 * p), rd);
            check("R1 default mask", rd, 32'h0001FFFF);
        end

        // R4 unmapped reads
        cfg_read(8'h31, 8'h44, rd); check("R4 read offset 0x44", rd, 32'h0);
        cfg_read(8'h31, 8'h15, rd); check("R4 read unaligned", rd, 32'h0);
        cfg_read(8'h30, 8'h14, rd); check("R4 read wrong page", rd, 32'h0);

        // R9 domain setup
        cfg_write(8'h31, 8'h14, 32'h00000300);
        cfg_write(8'h31, 8'h18, 32'h00000300);
        cfg_write(8'h31, 8'h28, 32'h00000300);
        cfg_read(8'h31, 8'h28, rd); check("R4 port10 write", rd, 32'h00000300);

        // R2 R5 R8 R9 vector table
        foreach (TBL[i]) begin
            send(TBL[i].port, TBL[i].dest, TBL[i].expect_vec, "R2/R9 table");
        end

        // R3 upper bits dropped
        cfg_write(8'h31, 8'h0C, 32'hABCD0005);
        cfg_read(8'h31, 8'h0C, rd); check("R3 upper bits dropped", rd, 32'h00010005);

        // R4 ignored writes
        cfg_write(8'h30, 8'h14, 32'h0);
        cfg_read(8'h31, 8'h14, rd); check("R4 wrong page write ignored", rd, 32'h00000300);
        cfg_write(8'h31, 8'h15, 32'h0);
        cfg_read(8'h31, 8'h14, rd); check("R4 unaligned write ignored", rd, 32'h00000300);
        cfg_write(8'h31, 8'h44, 32'h0);
        cfg_read(8'h31, 8'h44, rd); check("R4 offset 0x44 stays zero", rd, 32'h0);
        cfg_read(8'h31, 8'h40, rd); check("R4 port16 untouched", rd, 32'h0001FFFF);

        // R6 write in the accept cycle, stall, write again
        @(negedge clk);
        res_ready = 1'b0;
        req_valid = 1'b1; req_port = 5'd3; req_dest = 17'h1FFFF;
        cfg_page = 8'h31; cfg_offset = 8'h0C; cfg_wdata = 32'h2; cfg_wr_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; cfg_wr_en = 1'b0;
        check("R6 mask sampled at accept", {15'd0, res_vec}, 32'h00010005);
        check("R7 req_ready low in stall", {31'd0, req_ready}, 32'd0);
        cfg_write(8'h31, 8'h0C, 32'h4);
        check("R6 held result after write", {15'd0, res_vec}, 32'h00010005);
        check("R7 res_valid held", {31'd0, res_valid}, 32'd1);
        cfg_read(8'h31, 8'h0C, rd); check("R4 write during hold", rd, 32'h4);
        @(negedge clk);
        res_ready = 1'b1;
        @(negedge clk);
        check("R7 drained", {31'd0, res_valid}, 32'd0);
        send(5'd3, 17'h1FFFF, 17'h00004, "R6 new mask used");

        // R10 back-to-back
        @(negedge clk);
        req_valid = 1'b1; req_port = 5'd8; req_dest = 17'h00003;
        @(negedge clk);
        check("R10 first", {15'd0, res_vec}, 32'h3);
        req_port = 5'd9; req_dest = 17'h00200;
        @(negedge clk);
        check("R10 second", {15'd0, res_vec}, 32'h0);
        check("R10 still valid", {31'd0, res_valid}, 32'd1);
        req_port = 5'd16; req_dest = 17'h10001;
        @(negedge clk);
        check("R10 third", {15'd0, res_vec}, 32'h1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 idle after last", {31'd0, res_valid}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule